// File: doc/BRIEF.md
# Double-Buffered Crosspoint Connection Matrix

This block holds the connection map of an N-line crosspoint switch and resolves the logic level on every line from it. Each port pair has two bits. One is a staging bit that commands write. The other is a live bit, and only the live bit shapes the connections. Commands connect or disconnect a pair, detach one port from everything, or clear the whole map. All of them act on the staging bank only. The live bank is replaced by the staged one on any clock edge where the commit input `update` is high. A system can therefore prepare a complete new map in the background and switch to it in a single cycle. If `update` is held high, every command becomes live on the edge that accepts it.

Live connections are transitive, so the lines they join form nets. Each line reports the wired-AND of every driver in its net. A line that nobody drives reads as 1. One line can join any number of others. A registered pair query reports whether two ports are joined in the live bank.

Top module: `xpt_matrix`

## Requirements
- R1: A synchronous reset clears both banks, sets `qry_hit` to 0 and sets every `line_val` bit to 1.
- R2: A command accepted while `update` is low changes only the staging bank. Queries and line values stay as they were until a commit.
- R3: On any edge where `update` is high, the whole live bank takes the staged contents at once, including a command accepted on that same edge.
- R4: While `update` is held high, a command is visible to a query issued in the cycle after it is accepted.
- R5: The map is symmetric. `cmd_op` 0 (link) with ports (a,b) joins b to a as well, and `cmd_op` 1 (unlink) given as (b,a) separates (a,b).
- R6: A link or unlink naming the same port twice has no effect, and a query of a port with itself returns 0.
- R7: `line_val[i]` equals the AND of `drv_val[j]` over every j with `drv_en[j]` high in the net of line i, where nets follow live links transitively. It is 1 when that net has no enabled driver, and the result is registered one cycle after the inputs.
- R8: `cmd_op` 2 (port clear) with port `cmd_a` removes every staged link that involves that port and leaves all other links intact.
- R9: `cmd_op` 3 (array clear) removes every staged link.
- R10: `qry_hit` shows, one cycle later, the live bit of the pair (`qry_a`,`qry_b`).
- R11: A unlink of a joined pair separates it after the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| update | input | 1 | Commit staged bank to live bank on this edge |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 link, 1 unlink, 2 port clear, 3 array clear |
| cmd_a | input | AW | First port of the command |
| cmd_b | input | AW | Second port of the command |
| qry_a | input | AW | First port of the pair query |
| qry_b | input | AW | Second port of the pair query |
| qry_hit | output | 1 | Registered live connection bit of the queried pair |
| drv_en | input | N | Per-line driver enable |
| drv_val | input | N | Per-line driven value |
| line_val | output | N | Registered resolved value of each line |

## Verification
The bench builds the block with N = 6. At that size every ordered pair of distinct ports can be linked, committed and unlinked in turn, and every port can be queried against every other. With a map that holds a two-hop chain and a one-to-many fan, all 64 driver-enable masks are applied. This covers transitive nets, undriven nets and nets with mixed drivers. The bench works out the expected line values with its own label-merging net model.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic [1:0] {
    XOP_LINK     = 2'd0,
    XOP_UNLINK   = 2'd1,
    XOP_PORT_CLR = 2'd2,
    XOP_ALL_CLR  = 2'd3
  } xop_e;
endpackage

// File: rtl/xpt_load_bank.sv
module xpt_load_bank
  import xpt_pkg::*;
#(
  parameter int N = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1,
  localparam int NB = N * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  xop_e          cmd_op,
  input  logic [AW-1:0] cmd_a,
  input  logic [AW-1:0] cmd_b,
  output logic [NB-1:0] load_q,
  output logic [NB-1:0] load_nx
);
  logic same_port;
  assign same_port = (cmd_a == cmd_b);

  always_comb begin
    load_nx = load_q;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        logic pair_hit;
        logic port_hit;
        pair_hit = ((AW'(i) == cmd_a) && (AW'(j) == cmd_b)) ||
                   ((AW'(i) == cmd_b) && (AW'(j) == cmd_a));
        port_hit = (AW'(i) == cmd_a) || (AW'(j) == cmd_a);
        if (cmd_valid) begin
          unique case (cmd_op)
            XOP_LINK:     if (pair_hit && !same_port) load_nx[i*N+j] = 1'b1;
            XOP_UNLINK:   if (pair_hit && !same_port) load_nx[i*N+j] = 1'b0;
            XOP_PORT_CLR: if (port_hit) load_nx[i*N+j] = 1'b0;
            XOP_ALL_CLR:  load_nx[i*N+j] = 1'b0;
            default:      ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) load_q <= '0;
    else     load_q <= load_nx;
  end
endmodule

// File: rtl/xpt_net_resolve.sv
module xpt_net_resolve #(
  parameter int N = 16,
  localparam int NB = N * N
) (
  input  logic [NB-1:0] conn,
  input  logic [N-1:0]  drv_en,
  input  logic [N-1:0]  drv_val,
  output logic [N-1:0]  line_res
);
  // A low level spreads across one link per pass; N-1 passes reach every line of a net.
  logic [N-1:0] low;

  always_comb begin
    low = drv_en & ~drv_val;
    for (int pass = 0; pass < N - 1; pass++) begin
      logic [N-1:0] nxt;
      for (int i = 0; i < N; i++)
        nxt[i] = low[i] | (|(conn[i*N +: N] & low));
      low = nxt;
    end
    line_res = ~low;
  end
endmodule

// File: rtl/xpt_matrix.sv
module xpt_matrix
  import xpt_pkg::*;
#(
  parameter int N = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1,
  localparam int NB = N * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          update,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_a,
  input  logic [AW-1:0] cmd_b,
  input  logic [AW-1:0] qry_a,
  input  logic [AW-1:0] qry_b,
  output logic          qry_hit,
  input  logic [N-1:0]  drv_en,
  input  logic [N-1:0]  drv_val,
  output logic [N-1:0]  line_val
);
  logic [NB-1:0] load_q;
  logic [NB-1:0] load_nx;
  logic [NB-1:0] act_q;
  logic [N-1:0]  line_res;
  logic          pair_bit;

  xpt_load_bank #(.N(N)) u_load (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (xop_e'(cmd_op)),
    .cmd_a    (cmd_a),
    .cmd_b    (cmd_b),
    .load_q   (load_q),
    .load_nx  (load_nx)
  );

  xpt_net_resolve #(.N(N)) u_net (
    .conn    (act_q),
    .drv_en  (drv_en),
    .drv_val (drv_val),
    .line_res(line_res)
  );

  // Commit takes the next staged image so a command and a commit on one edge combine.
  always_ff @(posedge clk) begin
    if (rst)         act_q <= '0;
    else if (update) act_q <= load_nx;
  end

  always_comb begin
    pair_bit = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if ((AW'(i) == qry_a) && (AW'(j) == qry_b)) pair_bit = act_q[i*N+j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qry_hit  <= 1'b0;
      line_val <= '1;
    end else begin
      qry_hit  <= pair_bit;
      line_val <= line_res;
    end
  end
endmodule

// File: rtl/xpt_matrix_chk.sv
module xpt_matrix_chk #(
  parameter int N = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1,
  localparam int NB = N * N
) (
  input logic          clk,
  input logic          rst,
  input logic          update,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [AW-1:0] qry_a,
  input logic [AW-1:0] qry_b,
  input logic          qry_hit,
  input logic [N-1:0]  drv_en,
  input logic [N-1:0]  line_val,
  input logic [NB-1:0] load_q,
  input logic [NB-1:0] act_q
);
  logic [NB-1:0] act_t;
  logic [NB-1:0] diag;
  logic          act_pair;

  always_comb begin
    diag     = '0;
    act_pair = 1'b0;
    for (int i = 0; i < N; i++) begin
      diag[i*N+i] = 1'b1;
      for (int j = 0; j < N; j++) begin
        act_t[i*N+j] = act_q[j*N+i];
        if ((AW'(i) == qry_a) && (AW'(j) == qry_b)) act_pair = act_q[i*N+j];
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (qry_hit == 1'b0) && (line_val == '1)); // R1
  AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst) !update |=> $stable(act_q)); // R2
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (rst) (update && !cmd_valid) |=> (act_q == $past(load_q))); // R3
  AST_SYMMETRIC: assert property (@(posedge clk) disable iff (rst) act_q == act_t); // R5
  AST_NO_SELF: assert property (@(posedge clk) disable iff (rst) (act_q & diag) == '0); // R6
  AST_UNDRIVEN_HIGH: assert property (@(posedge clk) disable iff (rst) (drv_en == '0) |=> (line_val == '1)); // R7
  AST_ALL_CLEAR: assert property (@(posedge clk) disable iff (rst) (cmd_valid && cmd_op == 2'd3 && update) |=> (act_q == '0)); // R9
  AST_QUERY_LIVE: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (qry_hit == $past(act_pair))); // R10
endmodule

bind xpt_matrix xpt_matrix_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .update   (update),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .qry_a    (qry_a),
  .qry_b    (qry_b),
  .qry_hit  (qry_hit),
  .drv_en   (drv_en),
  .line_val (line_val),
  .load_q   (load_q),
  .act_q    (act_q)
);

// File: tb/xpt_matrix_bench.sv
module xpt_matrix_bench;
  localparam int N = 6;
  localparam int AW = 3;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_LINK = 2'd0, OP_UNLINK = 2'd1, OP_PCLR = 2'd2, OP_ACLR = 2'd3;

  logic clk = 1'b0;
  logic rst, update, cmd_valid, qry_hit;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_a, cmd_b, qry_a, qry_b;
  logic [N-1:0] drv_en, drv_val, line_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit ld[N][N];
  bit ac[N][N];

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_matrix #(.N(N)) u_xpt_matrix (
    .clk(clk), .rst(rst), .update(update), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .qry_a(qry_a), .qry_b(qry_b), .qry_hit(qry_hit),
    .drv_en(drv_en), .drv_val(drv_val), .line_val(line_val)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int a, input int b, input bit upd);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = AW'(a); cmd_b = AW'(b); update = upd;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        bit hit;
        hit = (i == a && j == b) || (i == b && j == a);
        case (op)
          OP_LINK:   if (hit && a != b) ld[i][j] = 1;
          OP_UNLINK: if (hit && a != b) ld[i][j] = 0;
          OP_PCLR:   if (i == a || j == a) ld[i][j] = 0;
          default:   ld[i][j] = 0;
        endcase
      end
    if (upd) ac = ld;
    tick();
    cmd_valid = 1'b0; update = 1'b0;
  endtask

  task automatic commit;
    update = 1'b1;
    ac = ld;
    tick();
    update = 1'b0;
  endtask

  task automatic query(input string req, input int a, input int b, input bit exp);
    qry_a = AW'(a); qry_b = AW'(b);
    tick();
    check(req, 32'(qry_hit), 32'(exp));
  endtask

  function automatic logic [N-1:0] exp_lines(input logic [N-1:0] en, input logic [N-1:0] val);
    int lab[N];
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) lab[i] = i;
    for (int k = 0; k < N; k++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (ac[i][j] && lab[j] < lab[i]) lab[i] = lab[j];
          else if (ac[i][j] && lab[i] < lab[j]) lab[j] = lab[i];
    for (int i = 0; i < N; i++) begin
      r[i] = 1'b1;
      for (int j = 0; j < N; j++)
        if (lab[j] == lab[i] && en[j] && !val[j]) r[i] = 1'b0;
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; update = 0; cmd_valid = 0; cmd_op = 0; cmd_a = 0; cmd_b = 0;
    qry_a = 0; qry_b = 0; drv_en = 0; drv_val = 0;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin ld[i][j] = 0; ac[i][j] = 0; end
    repeat (3) tick();
    rst = 1'b0;
    // R1: reset state
    check("R1 lines", 32'(line_val), 32'({N{1'b1}}));
    for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) query("R1 query", a, b, 0);

    // Exhaustive pair sweep: R2, R3, R5, R4, R11
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) begin
        if (a == b) continue;
        cmd(OP_LINK, a, b, 0);
        query("R2 staged only", a, b, 0);
        commit();
        query("R3 R5 committed reverse", b, a, 1);
        cmd(OP_UNLINK, b, a, 1);
        query("R4 R11 immediate unlink", a, b, 0);
      end

    // R6: self pair ignored
    cmd(OP_LINK, 2, 2, 1);
    query("R6 self query", 2, 2, 0);
    drv_en = 6'b000100; drv_val = 6'b000000;
    tick();
    check("R6 self lines", 32'(line_val), 32'(6'b111011));
    drv_en = '0;

    // R3: several staged links appear together
    cmd(OP_LINK, 0, 1, 0);
    cmd(OP_LINK, 1, 2, 0);
    cmd(OP_LINK, 3, 4, 0);
    cmd(OP_LINK, 5, 3, 0);
    query("R2 staged batch", 3, 5, 0);
    commit();
    query("R3 batch 0-1", 0, 1, 1);
    query("R3 batch 4-3", 4, 3, 1);
    query("R3 batch 3-5", 3, 5, 1);
    query("R7 no direct 0-2", 0, 2, 0);

    // R7: all driver-enable masks over a chain and a fan
    for (int m = 0; m < 64; m++) begin
      drv_en = 6'(m);
      drv_val = 6'(m * 37 + 11);
      tick();
      check("R7 net value", 32'(line_val), 32'(exp_lines(drv_en, drv_val)));
    end
    drv_en = '0;
    tick();
    check("R7 undriven", 32'(line_val), 32'({N{1'b1}}));

    // R8: port clear
    cmd(OP_PCLR, 1, 0, 1);
    query("R8 0-1 cleared", 0, 1, 0);
    query("R8 2-1 cleared", 2, 1, 0);
    query("R8 3-4 kept", 3, 4, 1);
    drv_en = 6'b000001; drv_val = 6'b0;
    tick();
    check("R8 lines", 32'(line_val), 32'(exp_lines(drv_en, drv_val)));
    drv_en = '0;

    // R9: array clear, staged then committed
    cmd(OP_ACLR, 0, 0, 0);
    query("R2 clear staged", 5, 3, 1);
    commit();
    query("R9 3-5 cleared", 3, 5, 0);
    query("R9 4-3 cleared", 4, 3, 0);

    // R1: reset clears live connections
    cmd(OP_LINK, 4, 5, 1);
    query("R4 link live", 5, 4, 1);
    rst = 1'b1; tick(); rst = 1'b0;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin ld[i][j] = 0; ac[i][j] = 0; end
    query("R1 reset clears", 4, 5, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule